// File: doc/BRIEF.md
# Shared-Pool Virtual-Channel Flit Buffer

This block is the flit store of one router input port. All virtual channels draw storage slots from a single common pool, so how much space each channel holds depends on its current traffic rather than on a fixed split. A channel under heavy load can fill nearly the whole pool while idle channels hold nothing. Each channel is a queue whose length changes at run time. The queue is kept as a linked list through a shared next-slot table. A FIFO of spare slot indices hands out slots on writes and takes them back on reads.

The upstream side writes a flit together with its channel number. The downstream side names a channel and receives that channel's oldest flit one cycle later. Channels are independent, so a stalled channel never blocks the others. Every accepted read returns a credit pulse tagged with the channel number. Per-channel empty flags and a pool-full flag tell the two sides what they may request. An operation that cannot be carried out is dropped and raises a one-cycle error pulse.

Top module: `shared_vc_buffer`

## Requirements
- R1: After a synchronous active-low reset, every bit of `vc_empty` is 1, and `pool_full`, `rd_valid`, `crd_valid` and `err` are all 0.
- R2: Within one channel, flits are read out in the order they were written.
- R3: Reads from one channel return that channel's flits however writes to the channels were interleaved. A channel holding flits is never blocked by another channel's contents.
- R4: A single channel can take every slot of the pool, NUM_SLOTS flits. `pool_full` is 1 in the cycle after the last free slot is taken and 0 once any slot is returned.
- R5: A write while `pool_full` is 1 is dropped, even if a read frees a slot in the same cycle. `err` pulses in the next cycle, and no extra flit later appears on any channel.
- R6: A read of a channel whose `vc_empty` bit is 1 is dropped. In the next cycle `err` is 1 and both `rd_valid` and `crd_valid` are 0. A write to that channel in the same cycle is still accepted.
- R7: Every accepted read gives one cycle with `crd_valid` = 1 and `crd_vc` equal to the channel read, in the same cycle as its `rd_valid`.
- R8: Returned slots are reused without loss. A read and a write accepted in the same cycle both take effect, including on the same channel when it holds a single flit.
- R9: `vc_empty[v]` is 1 exactly when channel v holds no flit, one cycle after the operations that changed it.
- R10: The data for an accepted read appears on `rd_flit` with `rd_valid` = 1 in the cycle after the request, and `rd_valid` is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_vc | input | VC_W | Channel of the written flit |
| wr_flit | input | FLIT_W | Flit to store |
| rd_en | input | 1 | Read request |
| rd_vc | input | VC_W | Channel to read from |
| rd_valid | output | 1 | rd_flit carries a read result |
| rd_flit | output | FLIT_W | Oldest flit of the requested channel |
| vc_empty | output | NUM_VC | Per-channel empty flags |
| pool_full | output | 1 | No free slot remains |
| crd_valid | output | 1 | Credit return pulse |
| crd_vc | output | VC_W | Channel of the returned credit |
| err | output | 1 | A request in the previous cycle was dropped |

## Verification
Short single-channel bursts show that order is kept inside one queue. Interleaved writes to several channels, drained in a different channel order, show that the linked lists keep each channel's flits apart and that no channel waits on another. Filling the whole pool through one channel, then writing and reading at the limits, separates correct full and empty refusal from off-by-one slot accounting. Reading the same channel in the same cycle as a single-flit write isolates the head-pointer hand-over. A long run of random mixed traffic recycles every slot many times, which would expose a leaked or duplicated free-list entry.

// File: rtl/svb_pkg.sv
// Shared constants for the shared-pool VC buffer.
// Assumes: consumers derive widths from their own parameters; these are defaults only.
package svb_pkg;
    localparam int unsigned DEF_NUM_VC    = 4;
    localparam int unsigned DEF_NUM_SLOTS = 16;
    localparam int unsigned DEF_FLIT_W    = 32;
endpackage

// File: rtl/svb_free_list.sv
// Circular FIFO of spare slot indices. Reset preloads it with every index.
// Assumes: pop only when avail_cnt > 0; push never exceeds capacity (the caller
// only returns slots it previously popped).
module svb_free_list #(
    parameter int unsigned NUM_SLOTS = 16,
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
    localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              push,
    input  logic [SLOT_W-1:0] push_idx,
    output logic [SLOT_W-1:0] top_idx,
    output logic [CNT_W-1:0]  avail_cnt
);
    logic [SLOT_W-1:0] idx_mem [NUM_SLOTS];
    logic [SLOT_W-1:0] rptr, wptr;

    // Advance a pointer with wrap at the last slot.
    function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
        return (p == SLOT_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    assign top_idx = idx_mem[rptr];

    // Preload on reset, otherwise take back freed slots and hand out spare ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) idx_mem[i] <= SLOT_W'(i);
            rptr      <= '0;
            wptr      <= '0;
            avail_cnt <= CNT_W'(NUM_SLOTS);
        end else begin
            if (push) begin
                idx_mem[wptr] <= push_idx;
                wptr          <= bump(wptr);
            end
            if (pop) rptr <= bump(rptr);
            avail_cnt <= avail_cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/svb_link_store.sv
// Slot storage: flit payload and next-slot link per slot, with one write port for
// each table and asynchronous reads at the selected head slot.
// Assumes: contents of a slot are meaningful only while the slot is on a queue.
module svb_link_store #(
    parameter int unsigned NUM_SLOTS = 16,
    parameter int unsigned FLIT_W    = 32,
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              data_we,
    input  logic [SLOT_W-1:0] data_slot,
    input  logic [FLIT_W-1:0] data_in,
    input  logic              link_we,
    input  logic [SLOT_W-1:0] link_from,
    input  logic [SLOT_W-1:0] link_to,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [FLIT_W-1:0] rd_data,
    output logic [SLOT_W-1:0] rd_next
);
    logic [FLIT_W-1:0] flit_mem [NUM_SLOTS];
    logic [SLOT_W-1:0] next_mem [NUM_SLOTS];

    assign rd_data = flit_mem[rd_slot];
    assign rd_next = next_mem[rd_slot];

    // Store an incoming flit into its newly taken slot.
    always_ff @(posedge clk) begin
        if (data_we) flit_mem[data_slot] <= data_in;
    end

    // Chain the new slot after the previous tail of its channel.
    always_ff @(posedge clk) begin
        if (link_we) next_mem[link_from] <= link_to;
    end
endmodule

// File: rtl/svb_vc_state.sv
// Head, tail and occupancy of one channel's linked queue.
// Assumes: wr_hit and rd_hit are already qualified (pool not full, queue not empty).
module svb_vc_state #(
    parameter int unsigned NUM_SLOTS = 16,
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
    localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [SLOT_W-1:0] new_slot,
    input  logic [SLOT_W-1:0] head_next,
    output logic [SLOT_W-1:0] head,
    output logic [SLOT_W-1:0] tail,
    output logic              empty
);
    logic [CNT_W-1:0] occ;
    logic             take_new_head;

    // New slot becomes head when the queue is empty, or when its only flit leaves now.
    assign take_new_head = wr_hit && ((occ == '0) || (rd_hit && occ == CNT_W'(1)));
    assign empty         = (occ == '0);

    // Track the queue ends and its length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (take_new_head)  head <= new_slot;
            else if (rd_hit)    head <= head_next;
            if (wr_hit)         tail <= new_slot;
            occ <= occ + CNT_W'(wr_hit) - CNT_W'(rd_hit);
        end
    end
endmodule

// File: rtl/shared_vc_buffer.sv
// Input-port flit buffer whose slots are shared by all channels through linked
// queues and a free-slot FIFO. Reads return data and a credit one cycle later.
// Assumes: NUM_VC >= 2, NUM_SLOTS >= 2; a write when full or a read of an empty
// channel is dropped and flagged on err.
module shared_vc_buffer #(
    parameter int unsigned NUM_VC    = svb_pkg::DEF_NUM_VC,
    parameter int unsigned NUM_SLOTS = svb_pkg::DEF_NUM_SLOTS,
    parameter int unsigned FLIT_W    = svb_pkg::DEF_FLIT_W,
    localparam int unsigned VC_W   = $clog2(NUM_VC),
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
    localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [VC_W-1:0]   wr_vc,
    input  logic [FLIT_W-1:0] wr_flit,
    input  logic              rd_en,
    input  logic [VC_W-1:0]   rd_vc,
    output logic              rd_valid,
    output logic [FLIT_W-1:0] rd_flit,
    output logic [NUM_VC-1:0] vc_empty,
    output logic              pool_full,
    output logic              crd_valid,
    output logic [VC_W-1:0]   crd_vc,
    output logic              err
);
    logic [SLOT_W-1:0] heads [NUM_VC];
    logic [SLOT_W-1:0] tails [NUM_VC];
    logic [SLOT_W-1:0] new_slot, head_sel, head_next;
    logic [FLIT_W-1:0] head_data;
    logic [CNT_W-1:0]  avail_cnt;
    logic              wr_ok, rd_ok;

    assign pool_full = (avail_cnt == '0);
    assign wr_ok     = wr_en && !pool_full;
    assign rd_ok     = rd_en && !vc_empty[rd_vc];
    assign head_sel  = heads[rd_vc];

    svb_free_list #(.NUM_SLOTS(NUM_SLOTS)) free_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (wr_ok),
        .push      (rd_ok),
        .push_idx  (head_sel),
        .top_idx   (new_slot),
        .avail_cnt (avail_cnt)
    );

    svb_link_store #(.NUM_SLOTS(NUM_SLOTS), .FLIT_W(FLIT_W)) store_i (
        .clk       (clk),
        .data_we   (wr_ok),
        .data_slot (new_slot),
        .data_in   (wr_flit),
        .link_we   (wr_ok && !vc_empty[wr_vc]),
        .link_from (tails[wr_vc]),
        .link_to   (new_slot),
        .rd_slot   (head_sel),
        .rd_data   (head_data),
        .rd_next   (head_next)
    );

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        svb_vc_state #(.NUM_SLOTS(NUM_SLOTS)) state_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (wr_ok && (wr_vc == VC_W'(v))),
            .rd_hit    (rd_ok && (rd_vc == VC_W'(v))),
            .new_slot  (new_slot),
            .head_next (head_next),
            .head      (heads[v]),
            .tail      (tails[v]),
            .empty     (vc_empty[v])
        );
    end

    // Register read data, credit and the dropped-request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_flit   <= '0;
            crd_valid <= 1'b0;
            crd_vc    <= '0;
            err       <= 1'b0;
        end else begin
            rd_valid  <= rd_ok;
            crd_valid <= rd_ok;
            if (rd_ok) begin
                rd_flit <= head_data;
                crd_vc  <= rd_vc;
            end
            err <= (wr_en && !wr_ok) || (rd_en && !rd_ok);
        end
    end
endmodule

// File: rtl/svb_checker.sv
// Port-level temporal checks for shared_vc_buffer, attached by bind.
// Assumes: same parameter values as the bound instance.
module svb_checker #(
    parameter int unsigned NUM_VC = 4,
    localparam int unsigned VC_W = $clog2(NUM_VC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [VC_W-1:0]   wr_vc,
    input logic              rd_en,
    input logic [VC_W-1:0]   rd_vc,
    input logic              rd_valid,
    input logic [NUM_VC-1:0] vc_empty,
    input logic              pool_full,
    input logic              crd_valid,
    input logic [VC_W-1:0]   crd_vc,
    input logic              err
);
    p_credit_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !vc_empty[rd_vc]) |=> (crd_valid && rd_valid && crd_vc == $past(rd_vc)));

    p_empty_read_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && vc_empty[rd_vc]) |=> (err && !rd_valid && !crd_valid));

    p_full_write_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pool_full) |=> err);

    p_full_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pool_full && !rd_en) |=> pool_full);

    p_written_vc_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pool_full) |=> !vc_empty[$past(wr_vc)]);

    p_no_spurious_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !vc_empty[rd_vc]) |=> !rd_valid);

    p_no_spurious_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && pool_full) && !(rd_en && vc_empty[rd_vc])) |=> !err);
endmodule

bind shared_vc_buffer svb_checker #(.NUM_VC(NUM_VC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_vc     (wr_vc),
    .rd_en     (rd_en),
    .rd_vc     (rd_vc),
    .rd_valid  (rd_valid),
    .vc_empty  (vc_empty),
    .pool_full (pool_full),
    .crd_valid (crd_valid),
    .crd_vc    (crd_vc),
    .err       (err)
);

// File: tb/shared_vc_buffer_tb_top.sv
// Scoreboard bench: the driver predicts outcomes from a queue model, the monitor
// compares read results and credits as they appear.
module shared_vc_buffer_tb_top;
    localparam int NUM_VC    = 4;
    localparam int NUM_SLOTS = 16;
    localparam int FLIT_W    = 32;
    localparam int VC_W      = $clog2(NUM_VC);
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en, rd_en;
    logic [VC_W-1:0]   wr_vc, rd_vc;
    logic [FLIT_W-1:0] wr_flit;
    logic              rd_valid, pool_full, crd_valid, err;
    logic [FLIT_W-1:0] rd_flit;
    logic [NUM_VC-1:0] vc_empty;
    logic [VC_W-1:0]   crd_vc;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [FLIT_W-1:0] model_q [NUM_VC][$];
    logic [VC_W+FLIT_W-1:0] exp_q [$];
    logic [FLIT_W-1:0] next_flit = 32'h1000;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_vc_buffer #(.NUM_VC(NUM_VC), .NUM_SLOTS(NUM_SLOTS), .FLIT_W(FLIT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_vc(wr_vc), .wr_flit(wr_flit),
        .rd_en(rd_en), .rd_vc(rd_vc), .rd_valid(rd_valid), .rd_flit(rd_flit),
        .vc_empty(vc_empty), .pool_full(pool_full), .crd_valid(crd_valid),
        .crd_vc(crd_vc), .err(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_used();
        int n = 0;
        for (int v = 0; v < NUM_VC; v++) n += model_q[v].size();
        return n;
    endfunction

    // Monitor: compare each read result and its credit against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R10", "unexpected rd_valid", 1, 0);
            end else begin
                logic [VC_W+FLIT_W-1:0] e;
                e = exp_q.pop_front();
                check(rd_flit == e[FLIT_W-1:0], "R2", "rd_flit", rd_flit, e[FLIT_W-1:0]);
                check(crd_valid && crd_vc == e[VC_W+FLIT_W-1:FLIT_W], "R7", "credit",
                      {crd_valid, crd_vc}, {1'b1, e[VC_W+FLIT_W-1:FLIT_W]});
            end
        end else if (rst_n && crd_valid) begin
            check(0, "R7", "credit without read", 1, 0);
        end
    end

    // Driver: one cycle of stimulus, model update, and status checks after the edge.
    task automatic cyc(input bit w, input int wv, input bit r, input int rv, input string req);
        bit w_ok, r_ok, exp_err;
        logic [FLIT_W-1:0] d;
        d = next_flit;
        next_flit++;
        w_ok = w && (model_used() < NUM_SLOTS);
        r_ok = r && (model_q[rv].size() > 0);
        exp_err = (w && !w_ok) || (r && !r_ok);
        wr_en = w; wr_vc = VC_W'(wv); wr_flit = d;
        rd_en = r; rd_vc = VC_W'(rv);
        if (r_ok) exp_q.push_back({VC_W'(rv), model_q[rv].pop_front()});
        if (w_ok) model_q[wv].push_back(d);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check(err == exp_err, req, "err", err, exp_err);
        for (int v = 0; v < NUM_VC; v++)
            check(vc_empty[v] == (model_q[v].size() == 0), "R9", "vc_empty", vc_empty[v],
                  model_q[v].size() == 0);
        check(pool_full == (model_used() == NUM_SLOTS), "R4", "pool_full", pool_full,
              model_used() == NUM_SLOTS);
    endtask

    task automatic drain_all();
        for (int v = 0; v < NUM_VC; v++)
            while (model_q[v].size() > 0) cyc(0, 0, 1, v, "R2");
        cyc(0, 0, 0, 0, "R10");
    endtask

    initial begin
        rst_n = 0; wr_en = 0; rd_en = 0; wr_vc = 0; rd_vc = 0; wr_flit = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check(vc_empty == '1, "R1", "vc_empty", vc_empty, '1);
        check(!pool_full && !rd_valid && !crd_valid && !err, "R1", "flags",
              {pool_full, rd_valid, crd_valid, err}, 0);
        // R2: order within one channel
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R2");
        drain_all();
        // R3: interleaved channels, drained in another order
        for (int i = 0; i < 6; i++) cyc(1, (i % 3) + 1, 0, 0, "R3");
        cyc(0, 0, 1, 3, "R3");
        cyc(0, 0, 1, 2, "R3");
        cyc(1, 1, 1, 3, "R3");
        drain_all();
        // R4: one channel takes the whole pool
        for (int i = 0; i < NUM_SLOTS; i++) cyc(1, 3, 0, 0, "R4");
        // R5: write while full is dropped, also with a same-cycle read
        cyc(1, 0, 0, 0, "R5");
        cyc(1, 3, 1, 3, "R5");
        cyc(1, 2, 0, 0, "R4");
        drain_all();
        // R6: read of an empty channel, with a write to it in the same cycle
        cyc(0, 0, 1, 2, "R6");
        cyc(1, 2, 1, 2, "R6");
        // R8: same-cycle read and write on a channel holding one flit
        cyc(1, 2, 1, 2, "R8");
        cyc(1, 2, 1, 2, "R8");
        drain_all();
        // R8: long random mixed traffic recycles every slot
        for (int i = 0; i < 3000; i++)
            cyc($urandom_range(0, 99) < 55, $urandom_range(0, NUM_VC - 1),
                $urandom_range(0, 99) < 50, $urandom_range(0, NUM_VC - 1), "R8");
        drain_all();
        @(negedge clk);
        check(exp_q.size() == 0, "R10", "pending reads", exp_q.size(), 0);
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        int cnt = 0;
        while (!done && cnt < 100000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) check(0, "R10", "watchdog expired", cnt, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule